// File: doc/BRIEF.md
# Significand Normalize and Round Stage

This stage sits after the significand multiplier of a floating-point multiply unit. It takes the full-width product of two significands, each with its hidden one, and turns it into a rounded result fraction. A product in [2,4) is shifted right one place so that it lands in [1,2). The stage then works out the guard bit and the sticky bit at the position that the selected precision calls for, applies one of four IEEE rounding modes, and reports whether the result is inexact.

Single-precision results stay in the double-width layout. The stage rounds at the bit that becomes the last single fraction bit, and it clears the 29 fraction bits below that position. The exponent logic receives two separate increment bits. One reports the normalize shift. The other reports a rounding carry out of the top of the fraction, which forces a second renormalization. All outputs are registered, so a result appears one clock after its inputs.

Top module: `fmul_sig_round`

## Requirements
- R1: While reset is asserted, and after it, until the first input is captured, all outputs are 0.
- R2: When product bit 105 is 1, the product is taken one place to the right and `norm_inc_o` is 1. Otherwise the integer bit is bit 104 and `norm_inc_o` is 0.
- R3: With double precision (`sp_i`=0) and an exact product, `frac_o` equals the 52 product bits just below the integer bit.
- R4: Rounding mode 2'b00 is round-to-nearest-even. The result rounds up above the halfway point, truncates below it, and on an exact tie rounds so that the last kept bit is 0.
- R5: Rounding mode 2'b01 always truncates toward zero.
- R6: Rounding mode 2'b10 rounds up in magnitude only when the result is inexact and `sign_i` is 0. Otherwise it truncates.
- R7: Rounding mode 2'b11 rounds up in magnitude only when the result is inexact and `sign_i` is 1. Otherwise it truncates.
- R8: With single precision (`sp_i`=1), rounding happens at `frac_o` bit 29. Every product bit below that bit counts toward guard or sticky, and `frac_o[28:0]` is 0.
- R9: `inexact_o` is 1 exactly when any product bit below the active rounding position is 1.
- R10: When the rounding increment carries out of the kept fraction, `frac_o` is 0 and `round_inc_o` is 1. In all other cases `round_inc_o` is 0.
- R11: Outputs show the result of the inputs sampled at the previous rising clock edge, and they hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_i | input | 106 | Significand product, value in [1,4), binary point below bit 104 |
| sp_i | input | 1 | 1 selects single-precision rounding position |
| rmode_i | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| sign_i | input | 1 | Sign of the result, used by the directed modes |
| frac_o | output | 52 | Rounded result fraction |
| norm_inc_o | output | 1 | Exponent increment from the normalize shift |
| round_inc_o | output | 1 | Exponent increment from a rounding carry |
| inexact_o | output | 1 | Result is inexact |

## Verification
The bench targets ties at nearest-even with both an odd and an even last bit. A stage that rounded ties away from zero would return an odd fraction on the even-tie case. Single-precision cases place ones only below bit 29, or only in the bits below the double-width fraction. A stage that rounded at the double position, or that left out those deep bits from sticky, would give a wrong fraction or a missing inexact flag. All-ones fractions, both shifted and unshifted, probe the rounding carry. A stage that dropped the carry would leave `round_inc_o` low or return a fraction that is not zero.

// File: rtl/fmul_sig_round_pkg.sv
package fmul_sig_round_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_TO_POS    = 2'b10,
    RM_TO_NEG    = 2'b11
  } rmode_e;
endpackage

// File: rtl/fsr_normalize.sv
// One-place normalize: picks the integer bit and splits fraction/guard/sticky.
module fsr_normalize #(
  parameter int FRAC_W = 52,
  localparam int PROD_W = 2 * (FRAC_W + 1)
) (
  input  logic [PROD_W-1:0] prod_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              guard_o,
  output logic              sticky_o,
  output logic              shifted_o
);
  // n_lo holds everything below the integer bit after alignment
  logic [PROD_W-2:0] n_lo;

  always_comb begin
    shifted_o = prod_i[PROD_W-1];
    n_lo      = shifted_o ? prod_i[PROD_W-2:0] : {prod_i[PROD_W-3:0], 1'b0};
    frac_o    = n_lo[PROD_W-2 -: FRAC_W];
    guard_o   = n_lo[PROD_W-2-FRAC_W];
    sticky_o  = |n_lo[PROD_W-3-FRAC_W:0];
  end
endmodule

// File: rtl/fsr_rounder.sv
// Picks the rounding position by precision, decides the increment, adds it.
module fsr_rounder
  import fmul_sig_round_pkg::*;
#(
  parameter int FRAC_W    = 52,
  parameter int SP_FRAC_W = 23,
  localparam int DROP_W   = FRAC_W - SP_FRAC_W
) (
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              guard_i,
  input  logic              sticky_i,
  input  logic              sp_i,
  input  rmode_e            rmode_i,
  input  logic              sign_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              carry_o,
  output logic              inexact_o
);
  localparam logic [FRAC_W-1:0] SP_LOW_MASK = {{SP_FRAC_W{1'b0}}, {DROP_W{1'b1}}};
  localparam logic [FRAC_W:0]   SP_ULP      = {{SP_FRAC_W{1'b0}}, 1'b1, {DROP_W{1'b0}}};
  localparam logic [FRAC_W:0]   DP_ULP      = {{FRAC_W{1'b0}}, 1'b1};

  logic [FRAC_W-1:0] kept;
  logic              g_act, s_act, lsb, up;
  logic [FRAC_W:0]   sum;

  always_comb begin
    kept  = sp_i ? (frac_i & ~SP_LOW_MASK) : frac_i;
    g_act = sp_i ? frac_i[DROP_W-1] : guard_i;
    s_act = sp_i ? (|frac_i[DROP_W-2:0] | guard_i | sticky_i) : sticky_i;
    lsb   = sp_i ? frac_i[DROP_W] : frac_i[0];

    unique case (rmode_i)
      RM_NEAR_EVEN: up = g_act & (s_act | lsb);
      RM_TO_ZERO:   up = 1'b0;
      RM_TO_POS:    up = (g_act | s_act) & ~sign_i;
      RM_TO_NEG:    up = (g_act | s_act) & sign_i;
      default:      up = 1'b0;
    endcase

    sum       = {1'b0, kept} + (up ? (sp_i ? SP_ULP : DP_ULP) : '0);
    frac_o    = sum[FRAC_W-1:0];
    carry_o   = sum[FRAC_W];
    inexact_o = g_act | s_act;
  end
endmodule

// File: rtl/fmul_sig_round.sv
module fmul_sig_round
  import fmul_sig_round_pkg::*;
#(
  parameter int FRAC_W    = 52,
  parameter int SP_FRAC_W = 23,
  localparam int PROD_W   = 2 * (FRAC_W + 1),
  localparam int DROP_W   = FRAC_W - SP_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PROD_W-1:0] prod_i,
  input  logic              sp_i,
  input  logic [1:0]        rmode_i,
  input  logic              sign_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              norm_inc_o,
  output logic              round_inc_o,
  output logic              inexact_o
);
  logic [FRAC_W-1:0] n_frac, r_frac;
  logic              n_guard, n_sticky, n_shift, r_carry, r_inexact;

  fsr_normalize #(.FRAC_W(FRAC_W)) u_norm (
    .prod_i   (prod_i),
    .frac_o   (n_frac),
    .guard_o  (n_guard),
    .sticky_o (n_sticky),
    .shifted_o(n_shift)
  );

  fsr_rounder #(.FRAC_W(FRAC_W), .SP_FRAC_W(SP_FRAC_W)) u_round (
    .frac_i   (n_frac),
    .guard_i  (n_guard),
    .sticky_i (n_sticky),
    .sp_i     (sp_i),
    .rmode_i  (rmode_e'(rmode_i)),
    .sign_i   (sign_i),
    .frac_o   (r_frac),
    .carry_o  (r_carry),
    .inexact_o(r_inexact)
  );

  // next-state
  logic [FRAC_W-1:0] frac_d;
  logic              norm_d, rnd_d, inex_d;

  always_comb begin
    frac_d = r_frac;
    norm_d = n_shift;
    rnd_d  = r_carry;
    inex_d = r_inexact;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_o      <= '0;
      norm_inc_o  <= 1'b0;
      round_inc_o <= 1'b0;
      inexact_o   <= 1'b0;
    end else begin
      frac_o      <= frac_d;
      norm_inc_o  <= norm_d;
      round_inc_o <= rnd_d;
      inexact_o   <= inex_d;
    end
  end

  assert_carry_zero_frac_R10: assert property (@(posedge clk) disable iff (!rst_n)
    round_inc_o |-> (frac_o == '0));

  assert_sp_low_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sp_i) |-> (frac_o[DROP_W-1:0] == '0));

  assert_rz_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rmode_i) == 2'b01) |-> !round_inc_o);

  assert_exact_no_round_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !inexact_o |-> !round_inc_o);

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(prod_i) && $stable(sp_i) && $stable(rmode_i) && $stable(sign_i)
    |=> $stable(frac_o));
endmodule

// File: tb/fmul_sig_round_tb.sv
`timescale 1ns/1ps
module fmul_sig_round_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [105:0] prod;
  logic         sp;
  logic [1:0]   rm;
  logic         sign;
  logic [51:0]  frac;
  logic         norm_inc, round_inc, inexact;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [51:0] ONES = {52{1'b1}};

  always #2 clk = ~clk;

  fmul_sig_round u_dut (
    .clk(clk), .rst_n(rst_n), .prod_i(prod), .sp_i(sp), .rmode_i(rm),
    .sign_i(sign), .frac_o(frac), .norm_inc_o(norm_inc),
    .round_inc_o(round_inc), .inexact_o(inexact)
  );

  task automatic check(input string tag, input logic [51:0] ef,
                       input logic en, input logic er, input logic ei);
    n_run++;
    if (frac !== ef || norm_inc !== en || round_inc !== er || inexact !== ei) begin
      n_fail++;
      $display("FAIL %s: got frac=%h norm=%b rnd=%b inex=%b exp frac=%h norm=%b rnd=%b inex=%b",
               tag, frac, norm_inc, round_inc, inexact, ef, en, er, ei);
    end
  endtask

  // drive at falling edge, capture at rising edge, sample at next falling edge
  task automatic apply(input logic [1:0] top, input logic [51:0] f,
                       input logic [51:0] rest, input logic s,
                       input logic [1:0] m, input logic sg);
    @(negedge clk);
    prod = {top, f, rest};
    sp = s; rm = m; sign = sg;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset", 52'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_dp_exact;
    apply(2'b01, 52'h123456789ABCD, 52'h0, 1'b0, 2'b00, 1'b0);
    check("R3 R2 exact unshifted", 52'h123456789ABCD, 1'b0, 1'b0, 1'b0);
    apply(2'b10, 52'h2468ACE02468A, 52'h0, 1'b0, 2'b00, 1'b0);
    check("R2 shifted 10", 52'h2468ACE02468A >> 1, 1'b1, 1'b0, 1'b0);
    apply(2'b11, 52'h2468ACE02468A, 52'h0, 1'b0, 2'b00, 1'b0);
    check("R2 shifted 11", {1'b1, 51'(52'h2468ACE02468A >> 1)}, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_nearest;
    apply(2'b01, 52'h10, 52'h8000000000000, 1'b0, 2'b00, 1'b0);
    check("R4 tie even stays", 52'h10, 1'b0, 1'b0, 1'b1);
    apply(2'b01, 52'h1, 52'h8000000000000, 1'b0, 2'b00, 1'b0);
    check("R4 tie odd up", 52'h2, 1'b0, 1'b0, 1'b1);
    apply(2'b01, 52'h10, 52'h8000000000001, 1'b0, 2'b00, 1'b0);
    check("R4 above half", 52'h11, 1'b0, 1'b0, 1'b1);
    apply(2'b01, 52'h10, 52'h7FFFFFFFFFFFF, 1'b0, 2'b00, 1'b0);
    check("R4 R9 below half", 52'h10, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_directed;
    apply(2'b01, 52'h10, 52'hFFFFFFFFFFFFF, 1'b0, 2'b01, 1'b0);
    check("R5 toward zero", 52'h10, 1'b0, 1'b0, 1'b1);
    apply(2'b01, 52'h10, 52'h1, 1'b0, 2'b10, 1'b0);
    check("R6 pos sign0 up", 52'h11, 1'b0, 1'b0, 1'b1);
    apply(2'b01, 52'h10, 52'h1, 1'b0, 2'b10, 1'b1);
    check("R6 pos sign1 trunc", 52'h10, 1'b0, 1'b0, 1'b1);
    apply(2'b01, 52'h10, 52'h0, 1'b0, 2'b10, 1'b0);
    check("R6 R9 exact no up", 52'h10, 1'b0, 1'b0, 1'b0);
    apply(2'b01, 52'h10, 52'h1, 1'b0, 2'b11, 1'b1);
    check("R7 neg sign1 up", 52'h11, 1'b0, 1'b0, 1'b1);
    apply(2'b01, 52'h10, 52'h1, 1'b0, 2'b11, 1'b0);
    check("R7 neg sign0 trunc", 52'h10, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_carry;
    apply(2'b01, ONES, 52'h8000000000000, 1'b0, 2'b00, 1'b0);
    check("R10 dp carry", 52'h0, 1'b0, 1'b1, 1'b1);
    apply(2'b11, ONES, 52'h0, 1'b0, 2'b00, 1'b0);
    check("R10 R2 shifted carry", 52'h0, 1'b1, 1'b1, 1'b1);
    apply(2'b01, ONES, 52'h0, 1'b1, 2'b00, 1'b0);
    check("R10 R8 sp carry", 52'h0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_single;
    apply(2'b01, {23'h5A5A5A, 29'h0}, 52'h0, 1'b1, 2'b00, 1'b0);
    check("R8 sp exact", {23'h5A5A5A, 29'h0}, 1'b0, 1'b0, 1'b0);
    apply(2'b01, {23'h1, 29'h10000000}, 52'h0, 1'b1, 2'b00, 1'b0);
    check("R8 sp tie odd up", {23'h2, 29'h0}, 1'b0, 1'b0, 1'b1);
    apply(2'b01, {23'h2, 29'h10000000}, 52'h1, 1'b1, 2'b00, 1'b0);
    check("R8 R9 sp deep sticky", {23'h3, 29'h0}, 1'b0, 1'b0, 1'b1);
    apply(2'b01, {23'h2, 29'h0}, 52'h1, 1'b1, 2'b01, 1'b0);
    check("R9 sp deep inexact", {23'h2, 29'h0}, 1'b0, 1'b0, 1'b1);
    apply(2'b01, {23'h7, 29'h1FFFFFFF}, 52'h0, 1'b1, 2'b01, 1'b0);
    check("R8 R5 sp truncate", {23'h7, 29'h0}, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_latency;
    apply(2'b01, 52'hABC, 52'h0, 1'b0, 2'b00, 1'b0);
    @(negedge clk);
    prod = {2'b01, 52'hDEF, 52'h0};
    #1;
    check("R11 hold before edge", 52'hABC, 1'b0, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R11 after edge", 52'hDEF, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    prod = '0; sp = 1'b0; rm = 2'b00; sign = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dp_exact();
    t_nearest();
    t_directed();
    t_carry();
    t_single();
    t_latency();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung exp finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule